// File: doc/BRIEF.md
# Static-Order Bus Grant Controller

This block is the central controller for a memory bus shared by several processors whose shared-memory accesses follow an order fixed at compile time. Processors never ask for the bus. While the controller is idle, a host writes a schedule into an internal list. Each list entry names the processor that owns one shared transaction, the shared-memory address that transaction uses, and whether it is a write. The host also gives the index of the final entry.

After a start pulse, the controller grants the bus to the processor named by entry zero. It keeps that grant until the owner pulses a single release line that all processors share. It then grants the bus to the owner of the next entry. After the final entry it wraps back to entry zero, so a periodic schedule repeats with no host involvement.

With each grant, the controller also drives the entry's address and direction onto the memory side. A read can therefore complete before the owner asks for it. A processor that reaches a shared access without the grant just waits. The grant appears both as one line per processor and as an encoded index with a valid flag.

Top module: `static_order_bus_ctrl`

## Requirements
- R1: After reset, `busy`, `grant_vld`, every `grant` line, `grant_idx`, `mem_addr` and `mem_wr` are all zero.
- R2: A `start` pulse while idle (with `stop` low) makes `busy` high on the next clock edge. At that same edge, the outputs take their values from list entry 0: `grant` has only bit number `proc` set, `grant_idx` equals `proc`, and `mem_addr` and `mem_wr` equal the entry's address and write flag.
- R3: While running, the grant outputs and the memory-side outputs stay unchanged on every edge where no new release pulse is seen and `stop` is low.
- R4: A release pulse is a rise of `release_in` (high now, low at the previous edge). It advances the outputs to the next list entry at the edge where the rise is seen. Holding `release_in` high for further cycles advances nothing more.
- R5: A release pulse seen while the entry at index `last_entry` (captured at start) is granted returns the outputs to entry 0.
- R6: Writes through the load port (`load_en`, at index `load_idx`) take effect only while idle. A write attempted while running leaves that entry unchanged.
- R7: At most one `grant` line is high at a time, and while `grant_vld` is high the line selected by `grant_idx` is the high one.
- R8: `stop` while running returns the block to idle on the next edge, with all grant and memory-side outputs zero. A later `start` begins again at entry 0.
- R9: While idle, pulses on `release_in` have no effect: all grants stay low and the next start still begins at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write one list entry (accepted only while idle) |
| load_idx | input | IDX_W | Index of the entry being written |
| load_proc | input | PID_W | Processor number stored in the entry |
| load_addr | input | ADDR_W | Shared-memory address stored in the entry |
| load_wr | input | 1 | Direction stored in the entry: 1 = write, 0 = read |
| last_entry | input | IDX_W | Index of the final entry of the schedule, captured at start |
| start | input | 1 | Begin sequencing at entry 0 (used only while idle) |
| stop | input | 1 | Return to idle and drop every grant |
| release_in | input | 1 | Shared release line; a rise ends the current transaction |
| busy | output | 1 | Sequencing is active |
| grant | output | NUM_PROC | One grant line per processor |
| grant_idx | output | PID_W | Encoded number of the granted processor |
| grant_vld | output | 1 | `grant_idx` is valid |
| mem_addr | output | ADDR_W | Address driven to shared memory for the granted transaction |
| mem_wr | output | 1 | Direction of the granted transaction |

## Verification
The schedule is tried with single-cycle release pulses and with release held high for several cycles. Together these show whether the release line is acted on by edge or by level. One pass runs through a five-entry list and wraps, and a second pass uses a reloaded two-entry list. This shows that the wrap point comes from the captured final index and not from the list depth. The load port is exercised both while running and while idle, which separates a write that is correctly blocked from one that is accepted. Release pulses are also sent while idle and after a stop, to show that they cannot move the pointer.

// File: rtl/sogc_pkg.sv
package sogc_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/sogc_list_mem.sv
module sogc_list_mem #(
  parameter int DEPTH  = 16,
  parameter int PID_W  = 2,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PID_W-1:0]  wr_proc,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_dir,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PID_W-1:0]  rd_proc,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_dir
);
  localparam int ENT_W = PID_W + ADDR_W + 1;

  logic [ENT_W-1:0] ent_q [DEPTH];

  // one register slot per entry, each with its own decoded write enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ent_q[g] <= '0;
      else if (slot_en) ent_q[g] <= {wr_proc, wr_addr, wr_dir};
    end
  end

  logic [ENT_W-1:0] rd_ent;
  always_comb begin
    rd_ent = '0;
    if (32'(rd_idx) < DEPTH) rd_ent = ent_q[rd_idx];
  end

  assign {rd_proc, rd_addr, rd_dir} = rd_ent;
endmodule

// File: rtl/sogc_seq.sv
module sogc_seq
  import sogc_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             release_in,
  input  logic [IDX_W-1:0] last_entry,
  output logic             running,
  output logic             run_nxt,
  output logic [IDX_W-1:0] ptr_nxt,
  output logic             load_ok
);
  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             rel_q;
  logic             rel_rise;

  assign rel_rise = release_in && !rel_q;

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    last_d = last_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start && !stop) begin
          st_d   = SEQ_RUN;
          ptr_d  = '0;
          last_d = last_entry;
        end
      end
      SEQ_RUN: begin
        if (stop) begin
          st_d = SEQ_IDLE;
        end else if (rel_rise) begin
          ptr_d = (ptr_q == last_q) ? '0 : ptr_q + 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      ptr_q  <= '0;
      last_q <= '0;
      rel_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      last_q <= last_d;
      rel_q  <= release_in;
    end
  end

  assign running = (st_q == SEQ_RUN);
  assign run_nxt = (st_d == SEQ_RUN);
  assign ptr_nxt = ptr_d;
  assign load_ok = (st_q == SEQ_IDLE);
endmodule

// File: rtl/sogc_grant_out.sv
module sogc_grant_out #(
  parameter int NUM_PROC = 4,
  parameter int PID_W    = 2,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_nxt,
  input  logic [PID_W-1:0]    ent_proc,
  input  logic [ADDR_W-1:0]   ent_addr,
  input  logic                ent_dir,
  output logic [NUM_PROC-1:0] grant,
  output logic [PID_W-1:0]    grant_idx,
  output logic                grant_vld,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_wr
);
  logic [NUM_PROC-1:0] grant_d;
  logic [PID_W-1:0]    idx_d;
  logic [ADDR_W-1:0]   addr_d;
  logic                dir_d;
  logic                upd;

  for (genvar g = 0; g < NUM_PROC; g++) begin : g_dec
    assign grant_d[g] = run_nxt && (ent_proc == PID_W'(g));
  end

  assign idx_d  = run_nxt ? ent_proc : '0;
  assign addr_d = run_nxt ? ent_addr : '0;
  assign dir_d  = run_nxt && ent_dir;

  // registers move only while running or while dropping out of a run
  assign upd = run_nxt || grant_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant     <= '0;
      grant_idx <= '0;
      grant_vld <= 1'b0;
      mem_addr  <= '0;
      mem_wr    <= 1'b0;
    end else if (upd) begin
      grant     <= grant_d;
      grant_idx <= idx_d;
      grant_vld <= run_nxt;
      mem_addr  <= addr_d;
      mem_wr    <= dir_d;
    end
  end
endmodule

// File: rtl/static_order_bus_ctrl.sv
module static_order_bus_ctrl #(
  parameter int NUM_PROC   = 4,
  parameter int LIST_DEPTH = 16,
  parameter int ADDR_W     = 16,
  localparam int PID_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int IDX_W = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [IDX_W-1:0]    load_idx,
  input  logic [PID_W-1:0]    load_proc,
  input  logic [ADDR_W-1:0]   load_addr,
  input  logic                load_wr,
  input  logic [IDX_W-1:0]    last_entry,
  input  logic                start,
  input  logic                stop,
  input  logic                release_in,
  output logic                busy,
  output logic [NUM_PROC-1:0] grant,
  output logic [PID_W-1:0]    grant_idx,
  output logic                grant_vld,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_wr
);
  logic             run_nxt;
  logic [IDX_W-1:0] ptr_nxt;
  logic             load_ok;
  logic [PID_W-1:0] ent_proc;
  logic [ADDR_W-1:0] ent_addr;
  logic             ent_dir;

  sogc_seq #(.IDX_W(IDX_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stop       (stop),
    .release_in (release_in),
    .last_entry (last_entry),
    .running    (busy),
    .run_nxt    (run_nxt),
    .ptr_nxt    (ptr_nxt),
    .load_ok    (load_ok)
  );

  sogc_list_mem #(
    .DEPTH (LIST_DEPTH),
    .PID_W (PID_W),
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) list_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (load_en && load_ok),
    .wr_idx  (load_idx),
    .wr_proc (load_proc),
    .wr_addr (load_addr),
    .wr_dir  (load_wr),
    .rd_idx  (ptr_nxt),
    .rd_proc (ent_proc),
    .rd_addr (ent_addr),
    .rd_dir  (ent_dir)
  );

  sogc_grant_out #(
    .NUM_PROC(NUM_PROC),
    .PID_W   (PID_W),
    .ADDR_W  (ADDR_W)
  ) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_nxt   (run_nxt),
    .ent_proc  (ent_proc),
    .ent_addr  (ent_addr),
    .ent_dir   (ent_dir),
    .grant     (grant),
    .grant_idx (grant_idx),
    .grant_vld (grant_vld),
    .mem_addr  (mem_addr),
    .mem_wr    (mem_wr)
  );
endmodule

// File: rtl/static_order_bus_ctrl_chk.sv
module static_order_bus_ctrl_chk #(
  parameter int NUM_PROC = 4,
  parameter int ADDR_W   = 16,
  parameter int PID_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                stop,
  input logic                release_in,
  input logic                busy,
  input logic [NUM_PROC-1:0] grant,
  input logic [PID_W-1:0]    grant_idx,
  input logic                grant_vld,
  input logic [ADDR_W-1:0]   mem_addr
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R7

  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> grant[grant_idx]); // R7

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (grant == '0 && !grant_vld)); // R8

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !stop) |=> busy); // R2

  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy); // R8

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !release_in && !stop) |=> ($stable(grant) && $stable(mem_addr))); // R3

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy); // R9
endmodule

bind static_order_bus_ctrl static_order_bus_ctrl_chk #(
  .NUM_PROC(NUM_PROC),
  .ADDR_W  (ADDR_W),
  .PID_W   (PID_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .stop       (stop),
  .release_in (release_in),
  .busy       (busy),
  .grant      (grant),
  .grant_idx  (grant_idx),
  .grant_vld  (grant_vld),
  .mem_addr   (mem_addr)
);

// File: tb/static_order_bus_ctrl_tb_top.sv
`timescale 1ns/100ps
module static_order_bus_ctrl_tb_top;
  localparam int NP = 4;
  localparam int DEP = 16;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_en, load_wr, start, stop, release_in;
  logic [3:0]    load_idx, last_entry;
  logic [1:0]    load_proc;
  logic [AW-1:0] load_addr;
  logic          busy, grant_vld, mem_wr;
  logic [NP-1:0] grant;
  logic [1:0]    grant_idx;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  static_order_bus_ctrl #(.NUM_PROC(NP), .LIST_DEPTH(DEP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
    .load_proc(load_proc), .load_addr(load_addr), .load_wr(load_wr),
    .last_entry(last_entry), .start(start), .stop(stop), .release_in(release_in),
    .busy(busy), .grant(grant), .grant_idx(grant_idx), .grant_vld(grant_vld),
    .mem_addr(mem_addr), .mem_wr(mem_wr)
  );

  typedef struct {
    string       tag;
    bit          vld;
    int          proc;
    logic [15:0] addr;
    bit          wr;
  } exp_t;

  exp_t sb_q[$];
  event chk_ev;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  int          sp[5] = '{2, 0, 3, 1, 2};
  logic [15:0] sa[5] = '{16'h0100, 16'h0211, 16'h0322, 16'h0433, 16'h0544};
  bit          sw[5] = '{0, 1, 0, 1, 1};

  // monitor: pops expected items and compares them against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        logic [NP-1:0] eg;
        e = sb_q.pop_front();
        eg = e.vld ? (NP'(1) << e.proc) : '0;
        n_vec++;
        if (grant !== eg || grant_vld !== e.vld || busy !== e.vld ||
            grant_idx !== (e.vld ? 2'(e.proc) : 2'd0) ||
            mem_addr !== (e.vld ? e.addr : 16'h0) || mem_wr !== (e.vld && e.wr)) begin
          n_bad++;
          $display("FAIL %s: got busy=%b vld=%b grant=%b idx=%0d addr=%h wr=%b ; exp busy=%b vld=%b grant=%b idx=%0d addr=%h wr=%b",
                   e.tag, busy, grant_vld, grant, grant_idx, mem_addr, mem_wr,
                   e.vld, e.vld, eg, e.vld ? e.proc : 0, e.vld ? e.addr : 16'h0, e.vld && e.wr);
        end
      end
    end
  end

  task automatic push_chk(input string tag, input bit vld, input int p,
                          input logic [15:0] a, input bit w);
    exp_t e;
    e.tag = tag; e.vld = vld; e.proc = p; e.addr = a; e.wr = w;
    sb_q.push_back(e);
    ->chk_ev;
    #0.5;
  endtask

  task automatic exp_idle(input string tag);
    push_chk(tag, 1'b0, 0, 16'h0, 1'b0);
  endtask

  task automatic exp_ent(input string tag, input int i);
    push_chk(tag, 1'b1, sp[i], sa[i], sw[i]);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input int i, input int p, input logic [15:0] a, input bit w);
    load_en = 1'b1; load_idx = 4'(i); load_proc = 2'(p); load_addr = a; load_wr = w;
    tick();
    load_en = 1'b0;
  endtask

  task automatic rel_pulse();
    release_in = 1'b1; tick();
    release_in = 1'b0; tick();
  endtask

  task automatic do_start();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic do_stop();
    stop = 1'b1; tick(); stop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete; got hung ; exp finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; load_en = 0; load_wr = 0; start = 0; stop = 0; release_in = 0;
    load_idx = '0; last_entry = '0; load_proc = '0; load_addr = '0;
    repeat (3) tick();
    exp_idle("R1 reset state");
    rst_n = 1'b1;
    tick();
    exp_idle("R1 after reset release");

    for (int i = 0; i < 5; i++) load(i, sp[i], sa[i], sw[i]);
    last_entry = 4'd4;
    exp_idle("R9 idle after load");
    rel_pulse();
    exp_idle("R9 release while idle");

    do_start();
    exp_ent("R2 start grants entry 0", 0);
    repeat (3) tick();
    exp_ent("R3 grant held without release", 0);

    load(1, 3, 16'hDEAD, 1'b0);
    exp_ent("R6 load during run keeps grant", 0);

    release_in = 1'b1; tick();
    exp_ent("R4 release rise advances to entry 1", 1);
    exp_ent("R6 blocked load left entry 1 intact", 1);
    release_in = 1'b0; tick();
    exp_ent("R4 release fall does not advance", 1);

    release_in = 1'b1; tick();
    exp_ent("R4 held release advances once to entry 2", 2);
    repeat (3) tick();
    exp_ent("R4 held release no further advance", 2);
    release_in = 1'b0; tick();

    rel_pulse();
    exp_ent("R4 pulse to entry 3", 3);
    rel_pulse();
    exp_ent("R4 pulse to entry 4", 4);
    rel_pulse();
    exp_ent("R5 wrap after last entry", 0);

    do_stop();
    exp_idle("R8 stop drops grants");
    rel_pulse();
    rel_pulse();
    exp_idle("R9 release after stop ignored");
    do_start();
    exp_ent("R8 restart begins at entry 0", 0);
    do_stop();

    load(1, 3, 16'h0BEE, 1'b1);
    sp[1] = 3; sa[1] = 16'h0BEE; sw[1] = 1;
    last_entry = 4'd1;
    do_start();
    exp_ent("R2 start of short schedule", 0);
    rel_pulse();
    exp_ent("R6 idle load accepted in entry 1", 1);
    rel_pulse();
    exp_ent("R5 short schedule wraps at captured last index", 0);
    do_stop();
    exp_idle("R8 final stop");

    finish_run();
  end
endmodule